// File: doc/BRIEF.md
# Triangular Down-Spread Offset Generator

This block produces the frequency-offset word that a fractional feedback divider adds to its nominal value, so that the synthesized CPU clock is swept slowly below its nominal frequency and the spectral energy of its harmonics is spread out. On every reference tick the block advances one step along a symmetric triangle. The triangle starts at zero, falls linearly to a negative peak and climbs back to zero. The output is therefore never positive, and the clock can only slow down.

The peak is the nominal divider value multiplied by a fixed-point depth fraction with 16 fractional bits. A 2-bit code selects either no spread or one of three depths. Both the code and the nominal divider are sampled only at the top of the triangle, where the offset is zero. A change made in the middle of a sweep therefore never causes a frequency step. One sweep takes 512 ticks, which from a 14.31818 MHz reference gives a modulation rate just under 28 kHz. The offset is expressed in units of 2^-16 of one divider step and is meant for the CPU clock path only.

Top module: `sst_triangle_gen`

## Requirements
- R1: While reset is low, and after it is released, the offset is 0 and no depth is in effect.
- R2: With code 00 in effect, the offset stays at exactly 0 and the sweep position stays at the top.
- R3: At the triangle bottom, the offset equals -(nom_div * K). K is 327 for code 01, 655 for code 10 and 819 for code 11. These are 0.50%, 1.00% and 1.25% of 2^16, truncated toward zero.
- R4: Ticks advance a position p through 0..511. At p the offset is -floor(peak * t / 256), where t = p for p <= 256 and t = 512 - p otherwise. There is no dwell at either end.
- R5: The offset is never positive.
- R6: depth_code and nom_div are sampled only on a tick taken at p = 0. A change at any other point has no effect until the sweep returns to the top.
- R7: A cycle without ref_tick leaves the offset and the sweep position unchanged.
- R8: With a nonzero code in effect, the offset returns to 0 once every 512 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle enable per reference period |
| depth_code | input | 2 | Spread depth select: 00 off, 01 0.50%, 10 1.00%, 11 1.25% |
| nom_div | input | DIV_W (16) | Nominal divider value, unsigned integer |
| offset_o | output | DIV_W+FRAC_W-5 (27) | Signed offset, LSB = 2^-16 divider step, always <= 0 |

## Verification
The hardest situation to reach from the ports is a depth or divider change arriving in the middle of a sweep, including a switch to off. The block must keep sweeping with the old peak until the top and only then adopt the new setting. The stimulus changes the code and the divider partway down the falling edge, and again partway up the rising edge. The bench keeps its own count of the sweep position and predicts the exact tick at which the new peak, or a flat zero, must appear. It also leaves gaps without ticks to show that the sweep is frozen between them.

// File: rtl/sst_triangle_gen.sv
module sst_triangle_gen #(
  parameter int DIV_W     = 16,
  parameter int FRAC_W    = 16,
  parameter int HALF_LOG2 = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            ref_tick,
  input  logic [1:0]                      depth_code,
  input  logic [DIV_W-1:0]                nom_div,
  output logic signed [DIV_W+FRAC_W-6:0]  offset_o
);
  localparam int HALF   = 1 << HALF_LOG2;
  localparam int PERIOD = 2 * HALF;
  localparam int PH_W   = HALF_LOG2 + 1;
  localparam int K_W    = FRAC_W - 6;
  localparam int PK_W   = DIV_W + K_W;
  localparam int PR_W   = PK_W + HALF_LOG2;
  localparam logic [K_W-1:0] K_LO  = K_W'(((2 ** FRAC_W) * 5) / 1000);
  localparam logic [K_W-1:0] K_MID = K_W'((2 ** FRAC_W) / 100);
  localparam logic [K_W-1:0] K_HI  = K_W'(((2 ** FRAC_W) * 5) / 400);

  logic [1:0]      code_q;
  logic [PH_W-1:0] phase_q;
  logic [PK_W-1:0] peak_q;
  logic [K_W-1:0]  k_sel;
  logic [PH_W-1:0] tri_idx;
  logic [PR_W-1:0] prod;
  logic [PK_W-1:0] mag;
  logic            at_top;

  assign at_top = (phase_q == '0);

  always_comb begin
    case (depth_code)
      2'b01:   k_sel = K_LO;
      2'b10:   k_sel = K_MID;
      2'b11:   k_sel = K_HI;
      default: k_sel = '0;
    endcase
  end

  assign tri_idx  = (phase_q <= PH_W'(HALF)) ? phase_q : PH_W'(PERIOD) - phase_q;
  assign prod     = PR_W'(peak_q) * PR_W'(tri_idx);
  assign mag      = PK_W'(prod >> HALF_LOG2);
  assign offset_o = -$signed({1'b0, mag});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q  <= 2'b00;
      phase_q <= '0;
      peak_q  <= '0;
    end else if (ref_tick) begin
      if (at_top) begin
        code_q  <= depth_code;
        peak_q  <= PK_W'(nom_div) * PK_W'(k_sel);
        phase_q <= (depth_code != 2'b00) ? PH_W'(1) : '0;
      end else begin
        phase_q <= phase_q + PH_W'(1);
      end
    end
  end

  a_r5_not_positive: assert property (@(posedge clk) disable iff (!rst_n)
    offset_o <= 0);

  a_r2_off_flat: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q == 2'b00) |-> (offset_o == 0 && at_top));

  a_r6_hold_mid_sweep: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_tick && !at_top) |=> ($stable(code_q) && $stable(peak_q)));

  a_r7_idle_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_tick |=> ($stable(offset_o) && $stable(phase_q)));

  a_r4_falls_first_half: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_tick && phase_q < PH_W'(HALF)) |=> (offset_o <= $past(offset_o)));

  a_r8_top_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
    at_top |-> (offset_o == 0));
endmodule

// File: tb/sst_triangle_gen_tb.sv
module sst_triangle_gen_tb;
  localparam int DIV_W = 16;
  localparam int OW    = 27;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_tick = 1'b0;
  logic [1:0] depth_code = 2'b00;
  logic [DIV_W-1:0] nom_div = '0;
  logic signed [OW-1:0] offset_o;

  int n_checks = 0;
  int n_fail = 0;
  int bp = 0;
  int bcode = 0;
  longint bpeak = 0;

  sst_triangle_gen u_dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
    .depth_code(depth_code), .nom_div(nom_div), .offset_o(offset_o)
  );

  always #4 clk = ~clk;

  function automatic longint kval(input int c);
    case (c)
      1: return 327;
      2: return 655;
      3: return 819;
      default: return 0;
    endcase
  endfunction

  function automatic longint tri_of(input int p);
    return (p <= 256) ? p : 512 - p;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: offset actual %0d expected %0d (pos %0d code %0d)", req, act, exp, bp, bcode);
    end
  endtask

  task automatic step(input logic t);
    longint exp;
    longint act;
    string req;
    ref_tick = t;
    @(posedge clk);
    if (t) begin
      if (bp == 0) begin
        bcode = depth_code;
        bpeak = longint'(nom_div) * kval(depth_code);
        bp = (depth_code != 0) ? 1 : 0;
      end else begin
        bp = (bp + 1) % 512;
      end
    end
    @(negedge clk);
    exp = (bcode == 0) ? 0 : -((bpeak * tri_of(bp)) >>> 8);
    act = longint'(offset_o);
    if (bcode == 0) req = "R2";
    else if (!t) req = "R7";
    else if (bp == 256) req = "R3";
    else if (bp == 0) req = "R8";
    else req = "R4";
    check(req, act, exp);
    if (act > 0) check("R5", act, 0);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step(1'b1);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    longint noms [4] = '{1000, 65535, 37, 12345};
    depth_code = 2'b11;
    nom_div = 16'd5000;
    ref_tick = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", longint'(offset_o), 0);
    rst_n = 1'b1;
    ref_tick = 1'b0;
    depth_code = 2'b00;
    @(negedge clk);
    check("R1", longint'(offset_o), 0);

    run(600);

    for (int c = 1; c < 4; c++) begin
      for (int j = 0; j < 4; j++) begin
        depth_code = 2'(c);
        nom_div = 16'(noms[j]);
        run(1024);
      end
    end

    // R6: mid-sweep code and divider change on the falling edge, then on the rising edge
    depth_code = 2'b11; nom_div = 16'd40000;
    run(100);
    depth_code = 2'b01; nom_div = 16'd9000;
    run(700);
    depth_code = 2'b10; nom_div = 16'd65535;
    run(600);
    // R6: switching off mid-sweep finishes the current sweep first
    depth_code = 2'b00;
    run(600);

    // R7: gaps without ticks
    depth_code = 2'b11; nom_div = 16'd30000;
    run(50);
    for (int g = 0; g < 40; g++) step(1'b0);
    run(300);
    for (int g = 0; g < 40; g++) step(1'b0);
    run(200);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule